// File: doc/BRIEF.md
# Audio Link Digital-Output Slot Selector

This block sits in the digital side of an audio codec. It picks the left/right sample pair that feeds a digital audio output (S/PDIF or I2S). The pair comes either from two time slots of the frame-based link from the controller or from the codec's own ADC. Three strap pins are sampled once, on the first clock edge after the active-low reset is released:
- The output-enable strap switches the digital output on with no software action.
- The codec-ID strap (inverting sense) selects the primary or the secondary role.
- The data-output strap reports whether the external output parts are fitted.

The captured straps decide which slot pair is used by default. Software may then select any of the four supported slot pairs through a small configuration port.

The link side presents one slot at a time: a strobe, the slot number and the slot's sample. When the second slot of the selected pair arrives and the output is enabled, the block presents the pair for exactly one clock, together with a valid pulse. A sample-rate field exists for software compatibility. It only ever holds the 48 kHz code. Line encoding and serialization belong to the stage that follows.

Top module: `audio_dout_slot_sel`

## Requirements
- R1: The straps are captured only at the first clock edge after reset is released. Later changes on the strap pins alter no register read-back and no output until the next reset.
- R2: With the enable strap low, a codec-ID pin that is high gives slot-select code 01 after reset. A codec-ID pin that is low gives code 10. The software-enable bit (control bit 3) reads 0.
- R3: With the enable strap high, the slot-select code after reset is 00 whatever the codec-ID pin is. The software-enable bit reads 1, so `out_en_o` is high with no write.
- R4: The control register sits at address 0. Bits [1:0] select the slot pair, bit 2 selects the ADC source and bit 3 enables the output. The slot pairs are 00 = slots 3/4, 01 = 7/8, 10 = 6/9 and 11 = 10/11. A write replaces the strap default, and the register reads back what was written.
- R5: When enabled, the left sample is taken from the first slot of the selected pair. The right sample is taken from the second slot. `out_valid_o` is high for exactly the one cycle after the clock edge that accepts the second slot's strobe. `out_left_o`/`out_right_o` hold the pair in that cycle.
- R6: With the ADC-source bit set, the presented pair is the most recent pair accepted on the ADC strobe. The timing still follows the link's selected slots.
- R7: The sample-rate field at address 1 accepts a write only of the 48 kHz code (2). Any other written value is dropped, and reads always return 2.
- R8: The capability flag at address 2, bit 0, reads 1 when the data-output strap was low at capture. It reads 0 when that strap was high.
- R9: While the software-enable bit is 0, `out_valid_o` stays low whatever slots arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_en_i | input | 1 | Output-enable strap pin |
| strap_cid_i | input | 1 | Codec-ID strap pin, high = primary |
| strap_dout_i | input | 1 | Data-output pin level at start-up |
| slot_stb_i | input | 1 | One link slot is present this cycle |
| slot_num_i | input | 4 | Number of the present slot |
| slot_data_i | input | DW | Sample carried by the present slot |
| adc_stb_i | input | 1 | A new local ADC pair is present |
| adc_left_i | input | DW | Local ADC left sample |
| adc_right_i | input | DW | Local ADC right sample |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration address |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| cfg_rdata_o | output | CFG_W | Configuration read data, combinational |
| out_en_o | output | 1 | Digital output enabled |
| out_valid_o | output | 1 | One-cycle pulse: new pair presented |
| out_left_o | output | DW | Selected left sample |
| out_right_o | output | DW | Selected right sample |

## Verification
The bench builds the block with its default parameters: 20-bit samples, an 8-bit configuration word and rate code 2. With these, every slot number from 0 to 12 can be driven, and upper data bits can be set on rate writes, so a non-48 kHz value that happens to match in its low bits is still refused. Full-width random samples make swapped halves or a stale left sample visible. Four reset cycles with different strap combinations reach all three default slot pairs and both values of the capability flag.

// File: rtl/sls_pkg.sv
package sls_pkg;

    localparam int SLOT_W = 4;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_RATE = 2'd1;
    localparam logic [1:0] ADDR_CAPS = 2'd2;

    typedef enum logic [1:0] {
        SEL_3_4   = 2'b00,
        SEL_7_8   = 2'b01,
        SEL_6_9   = 2'b10,
        SEL_10_11 = 2'b11
    } slot_sel_e;

    typedef struct packed {
        logic [SLOT_W-1:0] left;
        logic [SLOT_W-1:0] right;
    } slot_pair_t;

    function automatic slot_pair_t pair_of(slot_sel_e s);
        slot_pair_t p;
        case (s)
            SEL_3_4:  begin p.left = SLOT_W'(3);  p.right = SLOT_W'(4);  end
            SEL_7_8:  begin p.left = SLOT_W'(7);  p.right = SLOT_W'(8);  end
            SEL_6_9:  begin p.left = SLOT_W'(6);  p.right = SLOT_W'(9);  end
            default:  begin p.left = SLOT_W'(10); p.right = SLOT_W'(11); end
        endcase
        return p;
    endfunction

    // Enable strap wins; otherwise the codec role picks the pair.
    function automatic slot_sel_e default_sel(logic en_pin, logic cid_pin);
        if (en_pin)       return SEL_3_4;
        else if (cid_pin) return SEL_7_8;
        else              return SEL_6_9;
    endfunction

endpackage

// File: rtl/sls_strap_latch.sv
module sls_strap_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic dout_pin_i,
    output logic capture_o,
    output logic cap_o
);

    typedef struct packed {
        logic done;
        logic cap;
    } strap_st_t;

    strap_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        capture_o = !st_q.done;
        if (!st_q.done) begin
            st_d.done = 1'b1;
            st_d.cap  = !dout_pin_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_o = st_q.cap;

    a_r1_straps_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> $stable(st_q));

    a_r8_cap_sense: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.done |=> (st_q.cap == !$past(dout_pin_i)));

endmodule

// File: rtl/sls_cfg_regs.sv
module sls_cfg_regs
    import sls_pkg::*;
#(
    parameter int              CFG_W    = 8,
    parameter int              RATE_W   = 4,
    parameter logic [RATE_W-1:0] RATE_48K = 4'h2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic             en_pin_i,
    input  logic             cid_pin_i,
    input  logic             cap_i,
    input  logic             we_i,
    input  logic [1:0]       addr_i,
    input  logic [CFG_W-1:0] wdata_i,
    output logic [CFG_W-1:0] rdata_o,
    output slot_sel_e        sel_o,
    output logic             adc_src_o,
    output logic             out_en_o
);

    localparam logic [CFG_W-1:0] RATE_WORD = CFG_W'(RATE_48K);

    typedef struct packed {
        slot_sel_e         sel;
        logic              adc_src;
        logic              sw_en;
        logic [RATE_W-1:0] rate;
    } cfg_st_t;

    cfg_st_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (capture_i) begin
            cfg_d.sel     = default_sel(en_pin_i, cid_pin_i);
            cfg_d.sw_en   = en_pin_i;
            cfg_d.adc_src = 1'b0;
        end else if (we_i) begin
            case (addr_i)
                ADDR_CTRL: begin
                    cfg_d.sel     = slot_sel_e'(wdata_i[1:0]);
                    cfg_d.adc_src = wdata_i[2];
                    cfg_d.sw_en   = wdata_i[3];
                end
                ADDR_RATE: begin
                    if (wdata_i == RATE_WORD) cfg_d.rate = RATE_48K;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.sel     <= SEL_3_4;
            cfg_q.adc_src <= 1'b0;
            cfg_q.sw_en   <= 1'b0;
            cfg_q.rate    <= RATE_48K;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        case (addr_i)
            ADDR_CTRL: rdata_o = CFG_W'({cfg_q.sw_en, cfg_q.adc_src, cfg_q.sel});
            ADDR_RATE: rdata_o = CFG_W'(cfg_q.rate);
            ADDR_CAPS: rdata_o = CFG_W'(cap_i);
            default:   rdata_o = '0;
        endcase
    end

    assign sel_o     = cfg_q.sel;
    assign adc_src_o = cfg_q.adc_src;
    assign out_en_o  = cfg_q.sw_en;

    // R2 / R3: defaults follow the pins seen at the capture edge
    a_r2_default_sel: assert property (@(posedge clk) disable iff (!rst_n)
        capture_i |=> (cfg_q.sel == default_sel($past(en_pin_i), $past(cid_pin_i))));

    a_r3_hw_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (capture_i && en_pin_i) |=> out_en_o);

    a_r7_rate_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && addr_i == ADDR_RATE && wdata_i == RATE_WORD) |=> $stable(cfg_q.rate));

    a_r7_rate_code: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.rate == RATE_48K);

endmodule

// File: rtl/sls_pair_capture.sv
module sls_pair_capture
    import sls_pkg::*;
#(
    parameter int DW = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_stb_i,
    input  logic [SLOT_W-1:0] slot_num_i,
    input  logic [DW-1:0]     slot_data_i,
    input  logic              adc_stb_i,
    input  logic [DW-1:0]     adc_left_i,
    input  logic [DW-1:0]     adc_right_i,
    input  slot_sel_e         sel_i,
    input  logic              adc_src_i,
    input  logic              en_i,
    output logic              valid_o,
    output logic [DW-1:0]     left_o,
    output logic [DW-1:0]     right_o
);

    typedef struct packed {
        logic [DW-1:0] link_l;
        logic [DW-1:0] adc_l;
        logic [DW-1:0] adc_r;
        logic          valid;
        logic [DW-1:0] out_l;
        logic [DW-1:0] out_r;
    } cap_st_t;

    cap_st_t    cp_d, cp_q;
    slot_pair_t pair;
    logic       hit_l, hit_r;

    always_comb begin
        pair  = pair_of(sel_i);
        hit_l = slot_stb_i && (slot_num_i == pair.left);
        hit_r = slot_stb_i && (slot_num_i == pair.right);

        cp_d       = cp_q;
        cp_d.valid = 1'b0;
        if (adc_stb_i) begin
            cp_d.adc_l = adc_left_i;
            cp_d.adc_r = adc_right_i;
        end
        if (hit_l) cp_d.link_l = slot_data_i;
        if (hit_r && en_i) begin
            cp_d.valid = 1'b1;
            cp_d.out_l = adc_src_i ? cp_q.adc_l : cp_q.link_l;
            cp_d.out_r = adc_src_i ? cp_q.adc_r : slot_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cp_q <= '0;
        else        cp_q <= cp_d;
    end

    assign valid_o = cp_q.valid;
    assign left_o  = cp_q.out_l;
    assign right_o = cp_q.out_r;

    a_r5_fires_on_right: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb_i && slot_num_i == pair.right && en_i) |=> valid_o);

    a_r5_link_right: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb_i && slot_num_i == pair.right && en_i && !adc_src_i)
            |=> (right_o == $past(slot_data_i)));

    a_r6_adc_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_stb_i && slot_num_i == pair.right && en_i && adc_src_i)
            |=> (left_o == $past(cp_q.adc_l) && right_o == $past(cp_q.adc_r)));

    a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !valid_o);

endmodule

// File: rtl/audio_dout_slot_sel.sv
module audio_dout_slot_sel
    import sls_pkg::*;
#(
    parameter int                DW       = 20,
    parameter int                CFG_W    = 8,
    parameter int                RATE_W   = 4,
    parameter logic [RATE_W-1:0] RATE_48K = 4'h2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_en_i,
    input  logic              strap_cid_i,
    input  logic              strap_dout_i,
    input  logic              slot_stb_i,
    input  logic [SLOT_W-1:0] slot_num_i,
    input  logic [DW-1:0]     slot_data_i,
    input  logic              adc_stb_i,
    input  logic [DW-1:0]     adc_left_i,
    input  logic [DW-1:0]     adc_right_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_addr_i,
    input  logic [CFG_W-1:0]  cfg_wdata_i,
    output logic [CFG_W-1:0]  cfg_rdata_o,
    output logic              out_en_o,
    output logic              out_valid_o,
    output logic [DW-1:0]     out_left_o,
    output logic [DW-1:0]     out_right_o
);

    logic      capture;
    logic      cap_flag;
    slot_sel_e sel;
    logic      adc_src;

    sls_strap_latch u_strap (
        .clk        (clk),
        .rst_n      (rst_n),
        .dout_pin_i (strap_dout_i),
        .capture_o  (capture),
        .cap_o      (cap_flag)
    );

    sls_cfg_regs #(
        .CFG_W    (CFG_W),
        .RATE_W   (RATE_W),
        .RATE_48K (RATE_48K)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .en_pin_i  (strap_en_i),
        .cid_pin_i (strap_cid_i),
        .cap_i     (cap_flag),
        .we_i      (cfg_we_i),
        .addr_i    (cfg_addr_i),
        .wdata_i   (cfg_wdata_i),
        .rdata_o   (cfg_rdata_o),
        .sel_o     (sel),
        .adc_src_o (adc_src),
        .out_en_o  (out_en_o)
    );

    sls_pair_capture #(
        .DW (DW)
    ) u_pair (
        .clk         (clk),
        .rst_n       (rst_n),
        .slot_stb_i  (slot_stb_i),
        .slot_num_i  (slot_num_i),
        .slot_data_i (slot_data_i),
        .adc_stb_i   (adc_stb_i),
        .adc_left_i  (adc_left_i),
        .adc_right_i (adc_right_i),
        .sel_i       (sel),
        .adc_src_i   (adc_src),
        .en_i        (out_en_o),
        .valid_o     (out_valid_o),
        .left_o      (out_left_o),
        .right_o     (out_right_o)
    );

endmodule

// File: tb/audio_dout_slot_sel_test.sv
module audio_dout_slot_sel_test;

    localparam int DW    = 20;
    localparam int CFG_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             strap_en_i = 1'b0, strap_cid_i = 1'b1, strap_dout_i = 1'b0;
    logic             slot_stb_i = 1'b0;
    logic [3:0]       slot_num_i = '0;
    logic [DW-1:0]    slot_data_i = '0;
    logic             adc_stb_i = 1'b0;
    logic [DW-1:0]    adc_left_i = '0, adc_right_i = '0;
    logic             cfg_we_i = 1'b0;
    logic [1:0]       cfg_addr_i = '0;
    logic [CFG_W-1:0] cfg_wdata_i = '0;
    logic [CFG_W-1:0] cfg_rdata_o;
    logic             out_en_o, out_valid_o;
    logic [DW-1:0]    out_left_o, out_right_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // bench model of the configuration
    logic [1:0]    m_sel;
    logic          m_adc, m_en, m_cap;
    logic [DW-1:0] m_adc_l, m_adc_r;

    audio_dout_slot_sel uut (.*);

    always #2ns clk = ~clk;

    function automatic logic [3:0] f_left(logic [1:0] s);
        case (s)
            2'b00: return 4'd3;
            2'b01: return 4'd7;
            2'b10: return 4'd6;
            default: return 4'd10;
        endcase
    endfunction

    function automatic logic [3:0] f_right(logic [1:0] s);
        case (s)
            2'b00: return 4'd4;
            2'b01: return 4'd8;
            2'b10: return 4'd9;
            default: return 4'd11;
        endcase
    endfunction

    function automatic logic [1:0] f_default(logic en, logic cid);
        if (en) return 2'b00;
        return cid ? 2'b01 : 2'b10;
    endfunction

    task automatic check(string req, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic do_reset(logic en, logic cid, logic dout);
        @(negedge clk);
        rst_n = 1'b0;
        strap_en_i = en; strap_cid_i = cid; strap_dout_i = dout;
        repeat (3) @(negedge clk);
        check("R5 reset valid low", out_valid_o, 0);
        check("R3 reset enable low", out_en_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        m_sel = f_default(en, cid); m_en = en; m_adc = 1'b0; m_cap = !dout;
        // R1: later strap moves must not matter
        strap_en_i = ~en; strap_cid_i = ~cid; strap_dout_i = ~dout;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [CFG_W-1:0] v);
        @(negedge clk);
        cfg_addr_i = a;
        #1ns;
        v = cfg_rdata_o;
    endtask

    task automatic reg_write(logic [1:0] a, logic [CFG_W-1:0] v);
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = v;
        @(negedge clk);
        cfg_we_i = 1'b0;
        if (a == 2'd0) begin
            m_sel = v[1:0]; m_adc = v[2]; m_en = v[3];
        end
    endtask

    task automatic check_regs(string req);
        logic [CFG_W-1:0] v;
        reg_read(2'd0, v);
        check({req, " ctrl"}, v, {4'b0, m_en, m_adc, m_sel});
        reg_read(2'd1, v);
        check("R7 rate readback", v, 8'd2);
        reg_read(2'd2, v);
        check("R8 capability", v, {7'b0, m_cap});
        check({req, " out_en"}, out_en_o, m_en);
    endtask

    task automatic adc_pulse();
        @(negedge clk);
        adc_stb_i = 1'b1;
        adc_left_i = DW'($urandom); adc_right_i = DW'($urandom);
        m_adc_l = adc_left_i; m_adc_r = adc_right_i;
        @(negedge clk);
        adc_stb_i = 1'b0;
    endtask

    task automatic run_frame(string req);
        logic [DW-1:0] lk_l;
        lk_l = '0;
        for (int s = 0; s < 13; s++) begin
            @(negedge clk);
            slot_stb_i = 1'b1; slot_num_i = 4'(s); slot_data_i = DW'($urandom);
            if (4'(s) == f_left(m_sel)) lk_l = slot_data_i;
            @(negedge clk);
            slot_stb_i = 1'b0;
            if (4'(s) == f_right(m_sel) && m_en) begin
                check({req, " valid"}, out_valid_o, 1);
                check({req, " left"},  out_left_o,  m_adc ? m_adc_l : lk_l);
                check({req, " right"}, out_right_o, m_adc ? m_adc_r : slot_data_i);
            end else begin
                check(m_en ? {req, " no valid"} : "R9 disabled", out_valid_o, 0);
            end
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end
    endtask

    initial begin
        logic [CFG_W-1:0] v;
        logic [CFG_W-1:0] w;
        void'($urandom(32'h5eed));
        m_adc_l = '0; m_adc_r = '0;

        // primary, enable strap low
        do_reset(1'b0, 1'b1, 1'b0);
        check_regs("R2 primary default");
        check_regs("R1 strap frozen");
        run_frame("R9");
        reg_write(2'd0, 8'h09);
        run_frame("R5 slots 7/8");

        // secondary, enable strap low, pull-up present
        do_reset(1'b0, 1'b0, 1'b1);
        check_regs("R2 secondary default");
        reg_write(2'd0, 8'h0A);
        run_frame("R5 slots 6/9");

        // enable strap high: output runs with no write
        do_reset(1'b1, 1'b0, 1'b0);
        check_regs("R3 hw enable");
        run_frame("R3 slots 3/4");

        do_reset(1'b1, 1'b1, 1'b1);
        check_regs("R3 hw enable primary");

        // override every code, link and ADC source
        for (int c = 0; c < 8; c++) begin
            reg_write(2'd0, 8'(4'b1000 | c));
            check_regs("R4 override");
            adc_pulse();
            run_frame(c[2] ? "R6 adc source" : "R4 link source");
        end

        // random control words and frames
        for (int i = 0; i < 24; i++) begin
            w = 8'($urandom_range(0, 15));
            reg_write(2'd0, w);
            check_regs("R4 random ctrl");
            if ($urandom_range(0, 1) == 1) adc_pulse();
            run_frame(w[2] ? "R6 random" : "R5 random");
        end

        // rate field
        for (int i = 0; i < 20; i++) begin
            w = 8'($urandom);
            if (i == 0) w = 8'h12;
            if (i == 1) w = 8'h02;
            reg_write(2'd1, w);
            reg_read(2'd1, v);
            check("R7 rate write refused", v, 8'd2);
        end

        check_regs("R1 final readback");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

endmodule